// File: doc/BRIEF.md
# Timer Bank Global Control

This block is the shared control point for a bank of eight timer channels. Software reaches it through a simple register bus. A write-1-to-set register enables channels. A write-1-to-clear register disables them. Reading either register returns the live enable vector. A 32-bit status word gathers each channel's interrupt flag, error flag and running flag. Software clears the interrupt and error flags by writing ones to them.

Towards the channels, the block drives one enable line and one run line per channel. The run line rises a fixed number of clocks (three by default) after the enable bit is set. It falls together with the enable bit. The channels return single-cycle interrupt and error event pulses, and these are latched as sticky flags. A single interrupt output reports whether any interrupt flag is pending. Address map: 0 enable-set, 1 enable-clear, 2 status, 3 unused.

Top module: `tbc_top`

## Requirements
- R1: While reset is low, and after reset is released, the enable vector, the run lines, every status flag and the interrupt output are all zero.
- R2: A write to address 0 sets every channel whose data bit (bits 7:0) is 1. Bits written as 0 leave their channel's enable unchanged.
- R3: A write to address 1 clears every channel whose data bit (bits 7:0) is 1. Bits written as 0, and data bits 15:8, have no effect.
- R4: A read of address 0 or address 1 returns the current enable vector in bits 7:0, with 1 meaning enabled, and zero in bits 31:8.
- R5: Any subset of channels is enabled or disabled by one write. A channel's run line falls in the same cycle in which its enable bit clears.
- R6: A channel's run line rises exactly three clock edges after the edge that sets its enable bit.
- R7: The status word at address 2 holds the interrupt flags in bits 7:0, the error flags in bits 15:8, the run lines in bits 23:16, and zero in bits 31:24.
- R8: A write to address 2 clears each interrupt or error flag whose data bit (bits 15:0) is 1. Flags written with 0 stay as they are.
- R9: An event pulse sets its flag. When an event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: The interrupt output is high exactly when at least one interrupt flag is set.
- R11: Address 3 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data (the only bits that are writable) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_irq | input | 8 | Per-channel interrupt event pulses |
| ev_err | input | 8 | Per-channel overflow or error event pulses |
| chan_en | output | 8 | Per-channel enable lines |
| chan_run | output | 8 | Per-channel run lines, delayed after enable |
| irq_out | output | 1 | OR of the interrupt flags |

## Verification
The hardest case to reach is a collision: a channel event that lands in the same clock as a clearing write to the same flag. In that case the set must win, while the write still clears other flags. The bench drives the event pulse and the bus write from a single falling edge so that both meet at one rising edge. It then reads the status word back. The start delay is checked by sampling the run line on each of the three edges after the enabling write. This pins the rise to one exact cycle rather than to a window.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int unsigned NUM_CH  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned RDATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbc_enable_bank.sv
module tbc_enable_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;
  logic         en_ce;

  // Clear has priority over set for the same channel.
  always_comb begin
    en_ce = |set_mask | |clr_mask;
    en_d  = (en_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/tbc_start_delay.sv
module tbc_start_delay #(
  parameter int unsigned N   = 8,
  parameter int unsigned LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  output logic [N-1:0] run
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [LAT-1:0] pipe_q;
    logic [LAT-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[LAT-2:0], en[c]};
      // Run only after LAT consecutive enabled edges, drop with enable.
      run[c] = en[c] & (&pipe_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end
  end
endmodule

// File: rtl/tbc_flag_bank.sv
module tbc_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic         flag_ce;

  // Hardware set wins over a software clear in the same cycle.
  always_comb begin
    flag_ce = |hw_set | |sw_clr;
    flag_d  = (flag_q & ~sw_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/tbc_top.sv
module tbc_top
  import tbc_pkg::*;
#(
  parameter int unsigned START_LAT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2*NUM_CH-1:0] bus_wdata,
  output logic [RDATA_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0]   ev_irq,
  input  logic [NUM_CH-1:0]   ev_err,
  output logic [NUM_CH-1:0]   chan_en,
  output logic [NUM_CH-1:0]   chan_run,
  output logic                irq_out
);
  localparam int unsigned PAD_W = RDATA_W - 3*NUM_CH;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  reg_sel_e          sel;
  logic [NUM_CH-1:0] set_mask, clr_mask, irq_clr, err_clr;
  logic [NUM_CH-1:0] irq_flags, err_flags;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    set_mask = (bus_wr && sel == REG_EN_SET) ? bus_wdata[NUM_CH-1:0] : '0;
    clr_mask = (bus_wr && sel == REG_EN_CLR) ? bus_wdata[NUM_CH-1:0] : '0;
    irq_clr  = (bus_wr && sel == REG_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;
    err_clr  = (bus_wr && sel == REG_STATUS) ? bus_wdata[2*NUM_CH-1:NUM_CH] : '0;
  end

  tbc_enable_bank #(.N(NUM_CH)) u_enable (
    .clk(clk), .rst_n(core_rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask), .en_q(chan_en)
  );

  tbc_start_delay #(.N(NUM_CH), .LAT(START_LAT)) u_delay (
    .clk(clk), .rst_n(core_rst_n), .en(chan_en), .run(chan_run)
  );

  tbc_flag_bank #(.N(NUM_CH)) u_irq_flags (
    .clk(clk), .rst_n(core_rst_n),
    .hw_set(ev_irq), .sw_clr(irq_clr), .flag_q(irq_flags)
  );

  tbc_flag_bank #(.N(NUM_CH)) u_err_flags (
    .clk(clk), .rst_n(core_rst_n),
    .hw_set(ev_err), .sw_clr(err_clr), .flag_q(err_flags)
  );

  always_comb begin
    unique case (sel)
      REG_EN_SET, REG_EN_CLR: bus_rdata = {{(RDATA_W-NUM_CH){1'b0}}, chan_en};
      REG_STATUS:             bus_rdata = {{PAD_W{1'b0}}, chan_run, err_flags, irq_flags};
      default:                bus_rdata = '0;
    endcase
    irq_out = |irq_flags;
  end
endmodule

// File: rtl/tbc_top_chk.sv
module tbc_top_chk
  import tbc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [2*NUM_CH-1:0] bus_wdata,
  input logic [RDATA_W-1:0]  bus_rdata,
  input logic [NUM_CH-1:0]   ev_irq,
  input logic [NUM_CH-1:0]   chan_en,
  input logic [NUM_CH-1:0]   chan_run,
  input logic                irq_out
);
  // R2: bits written to the set register are enabled afterwards
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=>
      ((chan_en & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  // R3: bits written to the clear register are disabled afterwards
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=>
      ((chan_en & $past(bus_wdata[NUM_CH-1:0])) == '0));

  // R2, R3, R11: without an enable-register write the enable vector holds
  a_r11_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[1] == 1'b0) |=> $stable(chan_en));

  // R5: a run line is never high for a disabled channel
  a_r5_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_run & ~chan_en) == '0);

  // R6: a run line rises only when enable was already high three edges ago
  a_r6_start_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_run & ~$past(chan_run)) != '0) |->
      (((chan_run & ~$past(chan_run)) & ~$past(chan_en, 3)) == '0));

  // R9: an interrupt event always leaves its flag set on the next cycle
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_irq != '0) |=> (irq_out == 1'b1));

  // R10: interrupt output matches the flags seen through the status read
  a_r10_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (irq_out == (bus_rdata[NUM_CH-1:0] != '0)));
endmodule

bind tbc_top tbc_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_irq(ev_irq),
  .chan_en(chan_en), .chan_run(chan_run), .irq_out(irq_out)
);

// File: tb/tbc_top_test.sv
module tbc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk, rst_n, bus_wr, irq_out;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  ev_irq, ev_err, chan_en, chan_run;

  int checks = 0;
  int fails  = 0;

  // {write addr, write data, read addr, expected read}
  localparam logic [51:0] VEC [NVEC] = '{
    {2'd0, 16'h0005, 2'd0, 32'h0000_0005},  // R2 set
    {2'd0, 16'h0030, 2'd1, 32'h0000_0035},  // R4 R5 read via clear reg
    {2'd0, 16'h0000, 2'd0, 32'h0000_0035},  // R2 zeros no effect
    {2'd1, 16'h0011, 2'd1, 32'h0000_0024},  // R3 clear
    {2'd1, 16'h0000, 2'd0, 32'h0000_0024},  // R3 zeros no effect
    {2'd1, 16'hFF00, 2'd0, 32'h0000_0024},  // R3 high bits ignored
    {2'd3, 16'h00FF, 2'd0, 32'h0000_0024},  // R11 spare write
    {2'd3, 16'hFFFF, 2'd3, 32'h0000_0000},  // R11 spare read
    {2'd0, 16'h00C3, 2'd1, 32'h0000_00E7},  // R5 subset
    {2'd1, 16'h00FF, 2'd0, 32'h0000_0000}   // R5 clear all
  };

  tbc_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_irq(ev_irq),
    .ev_err(ev_err), .chan_en(chan_en), .chan_run(chan_run), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ev_irq = '0; ev_err = '0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R1 status in reset", v, 32'h0);
    check("R1 enable in reset", {24'h0, chan_en}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq_out}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] e;
      e = VEC[i];
      wr(e[51:50], e[49:34]);
      rd(e[33:32], v);
      check($sformatf("R2/R3/R4/R11 table entry %0d", i), v, e[31:0]);
    end

    // R6: run rises on the third edge after the enabling write
    wr(2'd0, 16'h0004);
    check("R6 run edge 0", {24'h0, chan_run}, 32'h0);
    @(negedge clk); check("R6 run edge 1", {24'h0, chan_run}, 32'h0);
    @(negedge clk); check("R6 run edge 2", {24'h0, chan_run}, 32'h0);
    @(negedge clk); check("R6 run edge 3", {24'h0, chan_run}, 32'h04);

    // R9 R7: events set flags, layout of status word
    ev_irq = 8'h81; ev_err = 8'h02;
    @(posedge clk); @(negedge clk);
    ev_irq = '0; ev_err = '0;
    rd(2'd2, v); check("R7 R9 status layout", v, 32'h0004_0281);
    check("R10 irq high", {31'h0, irq_out}, 32'h1);

    // R8: clear one interrupt flag, zeros untouched
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R8 partial clear", v, 32'h0004_0280);

    // R9: event and clearing write on the same flag at the same edge
    ev_irq = 8'h80;
    wr(2'd2, 16'h0280);
    ev_irq = '0;
    rd(2'd2, v); check("R9 set wins over clear", v, 32'h0004_0080);

    // R10: last flag cleared drops the interrupt
    wr(2'd2, 16'h0080);
    rd(2'd2, v); check("R8 all clear", v, 32'h0004_0000);
    check("R10 irq low", {31'h0, irq_out}, 32'h0);

    // R5: run falls together with enable
    wr(2'd1, 16'h0004);
    check("R5 run drops with enable", {24'h0, chan_run}, 32'h0);
    check("R5 enable cleared", {24'h0, chan_en}, 32'h0);

    // R6: re-enable pulse shorter than the delay never starts the channel
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0010);
    repeat (4) @(negedge clk);
    check("R6 short enable no run", {24'h0, chan_run}, 32'h0);

    // R1: asynchronous reset clears live state
    wr(2'd0, 16'h00FF);
    ev_irq = 8'h01; @(posedge clk); @(negedge clk); ev_irq = '0;
    rst_n = 1'b0; #1;
    check("R1 async reset enable", {24'h0, chan_en}, 32'h0);
    check("R1 async reset irq", {31'h0, irq_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule